// File: doc/BRIEF.md
# Protection-ID Permission Checker

This block decides whether a memory access may proceed once a translation entry has been found. Each request carries the page's access identifier, the page's own rights and the kind of access wanted. The block compares the identifier against four protection-ID registers and returns two things: the rights that remain in force, and a fault code naming the reason the access was refused.

Each protection-ID register stores an identifier shifted up by one bit. Its bit 0 is a write-disable flag. In wide mode a 64-bit register carries two such identifiers, one in each 32-bit half.

A write port loads the registers. The result of each request is registered and appears one cycle after the request strobe.

Top module: `pid_checker`

## Requirements
- R1: After reset all four ID registers read as zero, so a checked request with a nonzero identifier finds no match, and `rsp_valid` is low.
- R2: `rsp_valid` is high for exactly one cycle, one cycle after each cycle with `req_valid` high, and is low at all other times.
- R3: A cycle with `cfg_we` high loads `cfg_wdata` into register `cfg_idx`. Requests issued after that cycle use the new value.
- R4: A register half matches when `req_aid` equals its bits [16:1]. Bits above bit 16 of each half take no part in the comparison.
- R5: On a match, bit 0 of the matching half selects the granted rights. When bit 0 is 1 the grant is read+execute (3'b101). When bit 0 is 0 the grant is read+write+execute (3'b111). Access masks use bit 0 for read, bit 1 for write and bit 2 for execute.
- R6: Registers are searched from index 0 to index 3, and the first match alone decides the grant.
- R7: With `wide_mode` high, each register is tested on its low half ([31:0]) and then on its high half ([63:32]) before the next register is tested. With `wide_mode` low, only the low half is tested.
- R8: The ID check is skipped when `req_aid` is zero or `prot_en` is low. The effective rights are then the page rights.
- R9: When the ID check runs and the grant has no bit in common with `req_type`, the fault is 1 for a request with the execute bit set and 2 otherwise. The effective rights are then 0.
- R10: When the ID check passes, the effective rights are the page rights ANDed with the grant. If none of the requested bits remain, the fault is 1 for an execute request and 3 otherwise. Otherwise the fault is 0.
- R11: A request with `req_type` equal to 0 reports fault 0, and its effective rights equal the page rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 2 | Register index to write |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_type | input | 3 | Requested access mask (read, write, execute) |
| req_aid | input | 16 | Page access identifier |
| req_rights | input | 3 | Page rights mask |
| prot_en | input | 1 | Enables the ID check |
| wide_mode | input | 1 | Selects two identifiers per register |
| rsp_valid | output | 1 | Result strobe |
| rsp_rights | output | 3 | Effective rights |
| rsp_fault | output | 2 | 0 none, 1 instruction, 2 data ID, 3 data rights |

## Verification
The bench arranges duplicate identifiers across registers and across register halves. A search in the wrong order would then grant read+write+execute where read+execute should win, and a write that ought to fail with fault 2 would pass. It also places junk above bit 16 of a register, which exposes a comparator that uses too many bits. Further cases separate the ID fault from the rights fault, and the instruction code from the data codes. They also check that a public page, disabled protection and internal accesses skip the ID check. A design that mixed these up would report the wrong one of codes 1, 2 or 3, or would refuse an access that should pass.

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int AID_W = 16,
  parameter int NREG  = 4,
  parameter int REG_W = 64,
  localparam int IDX_W = $clog2(NREG),
  localparam int HALF  = REG_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [AID_W-1:0] req_aid,
  input  logic [2:0]       req_rights,
  input  logic             prot_en,
  input  logic             wide_mode,
  output logic             rsp_valid,
  output logic [2:0]       rsp_rights,
  output logic [1:0]       rsp_fault
);

  localparam logic [2:0] RX  = 3'b101;
  localparam logic [2:0] RWX = 3'b111;

  logic [REG_W-1:0] pid_q [NREG];
  logic             found;
  logic [2:0]       grant;
  logic             id_chk;
  logic [2:0]       eff;
  logic [1:0]       flt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) pid_q[i] <= '0;
    end else if (cfg_we) begin
      pid_q[cfg_idx] <= cfg_wdata;
    end
  end

  always_comb begin
    found = 1'b0;
    grant = 3'b000;
    for (int i = 0; i < NREG; i++) begin
      if (!found && pid_q[i][AID_W:1] == req_aid) begin
        found = 1'b1;
        grant = pid_q[i][0] ? RX : RWX;
      end
      if (!found && wide_mode && pid_q[i][HALF+AID_W:HALF+1] == req_aid) begin
        found = 1'b1;
        grant = pid_q[i][HALF] ? RX : RWX;
      end
    end
  end

  assign id_chk = prot_en && (req_aid != '0);

  always_comb begin
    eff = req_rights;
    flt = 2'd0;
    if (req_type != 3'b000) begin
      if (id_chk && (req_type & grant) == 3'b000) begin
        eff = 3'b000;
        flt = req_type[2] ? 2'd1 : 2'd2;
      end else begin
        if (id_chk) eff = req_rights & grant;
        if ((eff & req_type) == 3'b000) flt = req_type[2] ? 2'd1 : 2'd3;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rights <= 3'b000;
      rsp_fault  <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rights <= eff;
        rsp_fault  <= flt;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
  AST_INTERNAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'b000) |=> (rsp_fault == 2'd0)); // R11
  AST_RIGHTS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> ((rsp_rights & ~$past(req_rights)) == 3'b000)); // R10
  AST_EXEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type[2]) |=> (rsp_fault == 2'd0 || rsp_fault == 2'd1)); // R9
  AST_SKIP_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en && req_type != 3'b000) |=> (rsp_fault != 2'd2)); // R8

endmodule

// File: tb/pid_checker_test.sv
`timescale 1ns/1ps
module pid_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_type = '0;
  logic [15:0] req_aid = '0;
  logic [2:0]  req_rights = '0;
  logic        prot_en = 1'b0;
  logic        wide_mode = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] r; logic [1:0] f; string tag; } exp_t;
  exp_t q[$];

  localparam logic [15:0] A = 16'h1234;
  localparam logic [2:0] RD = 3'b001, WR = 3'b010, EX = 3'b100;

  always #2.5 clk = ~clk;

  pid_checker uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_type(req_type), .req_aid(req_aid), .req_rights(req_rights),
    .prot_en(prot_en), .wide_mode(wide_mode), .rsp_valid(rsp_valid),
    .rsp_rights(rsp_rights), .rsp_fault(rsp_fault));

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected rsp_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_rights !== e.r || rsp_fault !== e.f) begin
          fails++;
          $display("FAIL %s rights=%b fault=%0d expected rights=%b fault=%0d",
                   e.tag, rsp_rights, rsp_fault, e.r, e.f);
        end
      end
    end
  end

  task automatic cfg(input logic [1:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [2:0] t, input logic [15:0] aid, input logic [2:0] pr,
                       input logic pe, input logic wd, input logic [2:0] er,
                       input logic [1:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_aid = aid; req_rights = pr;
    prot_en = pe; wide_mode = wd;
    e.r = er; e.f = ef; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rsp_valid=%b expected=0", rsp_valid);
    end
    issue(RD, A, 3'b111, 1, 0, 3'b000, 2'd2, "R1 cleared regs no match");
    issue(EX, A, 3'b111, 1, 0, 3'b000, 2'd1, "R9 exec no match");
    issue(RD, A, 3'b111, 0, 0, 3'b111, 2'd0, "R8 prot disabled");
    issue(RD, 16'h0, 3'b001, 1, 0, 3'b001, 2'd0, "R8 public page");
    issue(3'b000, A, 3'b010, 1, 0, 3'b010, 2'd0, "R11 internal access");
    cfg(2'd0, 64'h2468);
    issue(WR, A, 3'b111, 1, 0, 3'b111, 2'd0, "R3 R5 write enabled match");
    issue(WR, A, 3'b101, 1, 0, 3'b101, 2'd3, "R10 page lacks write");
    issue(EX, A, 3'b011, 1, 0, 3'b011, 2'd1, "R10 page lacks exec");
    cfg(2'd0, 64'h2469);
    issue(WR, A, 3'b111, 1, 0, 3'b000, 2'd2, "R5 write disabled");
    issue(RD, A, 3'b111, 1, 0, 3'b101, 2'd0, "R5 read under write disable");
    cfg(2'd1, 64'h0000_0000_FFFE_2468);
    issue(WR, A, 3'b111, 1, 0, 3'b000, 2'd2, "R6 first register wins");
    cfg(2'd0, 64'h0);
    issue(WR, A, 3'b111, 1, 0, 3'b111, 2'd0, "R4 upper bits ignored");
    issue(WR, 16'h0234, 3'b111, 1, 0, 3'b000, 2'd2, "R4 mismatch");
    cfg(2'd1, 64'h0);
    cfg(2'd0, {32'h0000_2468, 32'h0000_2469});
    issue(WR, A, 3'b111, 1, 1, 3'b000, 2'd2, "R7 low half first");
    cfg(2'd0, {32'h0000_2468, 32'h0000_0002});
    issue(WR, A, 3'b111, 1, 0, 3'b000, 2'd2, "R7 narrow ignores high half");
    issue(WR, A, 3'b111, 1, 1, 3'b111, 2'd0, "R7 wide high half match");
    cfg(2'd1, 64'h2469);
    issue(WR, A, 3'b111, 1, 1, 3'b111, 2'd0, "R7 high half before next reg");
    issue(WR, A, 3'b111, 1, 0, 3'b000, 2'd2, "R7 narrow uses next reg");
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule